// File: doc/BRIEF.md
# SPI FIFO Status Flag Unit

This block keeps the status byte of an SPI peripheral that runs either with a single data buffer or with 8-entry transmit and receive FIFOs. It counts how full each FIFO is, using the push and pop strobes from the CPU side and the shift engine. From those counts it derives the full, empty and watermark flags. It also holds the event flags that software clears by writing 1. Two watermark interrupt requests are produced, each gated by its own enable.

The unit keeps its own copy of the SPI enable, the SPI mode and the FIFO mode control. When any of them changes, it performs a soft reset. Both FIFOs are emptied and the flags return to values that depend on the new FIFO mode. In buffered mode the read-full flag is sticky. It is cleared by a status read followed by a data read, or by a data read alone when receive DMA is on. In FIFO mode the read-full flag simply means that the receive FIFO is full.

Top module: `spi_fifo_status`

## Requirements
- R1: After the power-on reset, `status` is 0x20 (only bit 5, transmit-empty, is set) and both interrupt lines are 0. This holds until one of `spi_en`, `spi_mode` or `fifo_mode` changes.
- R2: A change of `spi_en`, `spi_mode` or `fifo_mode` causes a soft reset at the next clock edge. Both occupancies go to 0 and all strobes in that cycle are ignored. `status` then reads 0x25 if the new FIFO mode is 1, and 0x20 if it is 0.
- R3: In FIFO mode the transmit FIFO holds DEPTH (8) entries. Bit 1 (transmit-full) is 1 at occupancy 8 and bit 5 (transmit-empty) is 1 at occupancy 0. A push to a full FIFO or a pop from an empty one is ignored.
- R4: In FIFO mode `xfer_done` pushes to the receive FIFO and `data_rd` pops from it. Bit 0 (receive-empty) is 1 at occupancy 0 and bit 7 (read-full) is 1 at occupancy 8. Extra pushes and pops are ignored.
- R5: Bit 3 (receive-near-full) sets when the receive occupancy rises from below 6 to 6 or more. Bit 2 (transmit-near-empty) sets when the transmit occupancy falls from above 2 to 2 or less. Both stay set until they are cleared.
- R6: A write (`wr_stb`) clears bits 6, 4, 3 and 2 wherever `wr_data` has a 1. A 0 in `wr_data` leaves the bit alone, and the write has no effect on bits 7, 5, 1 and 0. A set event in the same cycle wins over the clear.
- R7: In buffered mode (FIFO mode 0), bits 3 to 0 read 0. The transmit buffer holds one entry: `tx_push` clears bit 5, a second push is ignored, and `tx_pop` sets bit 5 again.
- R8: In buffered mode, `xfer_done` sets bit 7 (read-full).
- R9: In buffered mode with `rx_dma_en` at 0, bit 7 clears only on a `data_rd` that comes in a later cycle than a `stat_rd` made while bit 7 was set. A new `xfer_done` requires a fresh status read.
- R10: In buffered mode with `rx_dma_en` at 1, `data_rd` alone clears bit 7.
- R11: `rx_nf_irq` equals bit 3 gated by `rx_nf_ie`, and `tx_ne_irq` equals bit 2 gated by `tx_ne_ie`.
- R12: `match_evt` sets bit 6 and `modf_evt` sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_en | input | 1 | SPI enable control |
| spi_mode | input | 1 | SPI mode control |
| fifo_mode | input | 1 | 1 selects FIFO mode |
| rx_dma_en | input | 1 | Receive DMA enable |
| rx_nf_ie | input | 1 | Receive-near-full interrupt enable |
| tx_ne_ie | input | 1 | Transmit-near-empty interrupt enable |
| tx_push | input | 1 | CPU wrote a transmit byte |
| tx_pop | input | 1 | Shift engine took a transmit byte |
| xfer_done | input | 1 | Transfer complete pulse |
| data_rd | input | 1 | Data register read strobe |
| stat_rd | input | 1 | Status register read strobe |
| wr_stb | input | 1 | Status write strobe |
| wr_data | input | 8 | Status write data (1 clears) |
| match_evt | input | 1 | Receive match event |
| modf_evt | input | 1 | Mode fault event |
| status | output | 8 | Status byte |
| rx_nf_irq | output | 1 | Receive-near-full interrupt request |
| tx_ne_irq | output | 1 | Transmit-near-empty interrupt request |

## Verification
The bench builds the block with its defaults: DEPTH 8, FIFO support on, receive watermark 6 and transmit watermark 2. With these values, full, empty and both watermark crossings are reached in a handful of strobes. A ninth push and a pop past empty can then be shown to be ignored, by watching when the empty flag returns. The small depth also makes it cheap to walk the sticky watermark flags through set, clear and no-re-set. It allows soft resets to be forced while both FIFOs hold data.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  // Status byte bit positions
  localparam int unsigned ST_RDFULL = 7;
  localparam int unsigned ST_MATCH  = 6;
  localparam int unsigned ST_TXEMP  = 5;
  localparam int unsigned ST_MODF   = 4;
  localparam int unsigned ST_RXNF   = 3;
  localparam int unsigned ST_TXNE   = 2;
  localparam int unsigned ST_TXFULL = 1;
  localparam int unsigned ST_RXEMP  = 0;

  // Sticky write-one-to-clear flags
  localparam int unsigned N_STICKY = 4;
  localparam int unsigned FL_MATCH = 0;
  localparam int unsigned FL_MODF  = 1;
  localparam int unsigned FL_RXNF  = 2;
  localparam int unsigned FL_TXNE  = 3;
  localparam int unsigned FLAG_POS [N_STICKY] = '{ST_MATCH, ST_MODF, ST_RXNF, ST_TXNE};

  typedef struct packed {
    logic spi_en;
    logic spi_mode;
    logic fifo_mode;
  } ctrl_t;

  // Occupancy after one cycle of accepted strobes
  function automatic int occ_next(int occ, bit push_ok, bit pop_ok);
    int r;
    r = occ;
    if (push_ok) r = r + 1;
    if (pop_ok)  r = r - 1;
    return r;
  endfunction

  // Count moves from below lvl to at or above lvl
  function automatic bit rises_to(int prv, int nxt, int lvl);
    return (prv < lvl) && (nxt >= lvl);
  endfunction

  // Count moves from above lvl to at or below lvl
  function automatic bit falls_to(int prv, int nxt, int lvl);
    return (prv > lvl) && (nxt <= lvl);
  endfunction

endpackage

// File: rtl/ssf_ctrl_watch.sv
module ssf_ctrl_watch
  import spi_stat_pkg::*;
#(
  parameter bit FIFO_SUPPORTED = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_in,
  output ctrl_t ctrl_eff,
  output ctrl_t ctrl_q,
  output logic  soft_rst
);

  generate
    if (FIFO_SUPPORTED) begin : g_fifo
      always_comb ctrl_eff = ctrl_in;
    end else begin : g_nofifo
      always_comb begin
        ctrl_eff = ctrl_in;
        ctrl_eff.fifo_mode = 1'b0;
      end
    end
  endgenerate

  assign soft_rst = (ctrl_eff != ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_eff;
  end

endmodule

// File: rtl/ssf_occ_counter.sv
module ssf_occ_counter
  import spi_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [OCC_W-1:0] cap,
  input  logic             push,
  input  logic             pop,
  output logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] occ_nxt
);

  logic push_ok;
  logic pop_ok;

  assign push_ok = push && (occ < cap);
  assign pop_ok  = pop && (occ != '0);
  assign occ_nxt = clr ? '0 : OCC_W'(occ_next(int'(occ), push_ok, pop_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_nxt;
  end

endmodule

// File: rtl/ssf_sticky_flag.sv
module ssf_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic soft_val,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (soft_rst) q <= soft_val;
    else if (set)      q <= 1'b1;
    else if (clr)      q <= 1'b0;
  end

endmodule

// File: rtl/ssf_rdfull.sv
module ssf_rdfull (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic active,
  input  logic set,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic dma_en,
  output logic flag
);

  logic armed;
  logic clr_hit;

  assign clr_hit = flag && data_rd && (dma_en || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (soft_rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (active) begin
      if (set) begin
        flag  <= 1'b1;
        armed <= 1'b0;
      end else if (clr_hit) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end else if (flag && stat_rd) begin
        armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_stat_pkg::*;
#(
  parameter int DEPTH          = 8,
  parameter int RX_NF_LVL      = 6,
  parameter int TX_NE_LVL      = 2,
  parameter bit FIFO_SUPPORTED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_en,
  input  logic       spi_mode,
  input  logic       fifo_mode,
  input  logic       rx_dma_en,
  input  logic       rx_nf_ie,
  input  logic       tx_ne_ie,
  input  logic       tx_push,
  input  logic       tx_pop,
  input  logic       xfer_done,
  input  logic       data_rd,
  input  logic       stat_rd,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       match_evt,
  input  logic       modf_evt,
  output logic [7:0] status,
  output logic       rx_nf_irq,
  output logic       tx_ne_irq
);

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

  // Named internal events
  ctrl_t            ctrl_in;
  ctrl_t            ctrl_eff;
  ctrl_t            ctrl_q;
  logic             soft_rst;
  logic             fifo_q;
  logic [OCC_W-1:0] tx_cap;
  logic [OCC_W-1:0] tx_occ, tx_nxt;
  logic [OCC_W-1:0] rx_occ, rx_nxt;
  logic             tx_push_g, tx_pop_g;
  logic             rx_push_g, rx_pop_g;
  logic             rx_nf_cross;
  logic             tx_ne_cross;
  logic             rdfull_nf;

  logic [N_STICKY-1:0] fl_set, fl_clr, fl_soft, fl_q;

  assign ctrl_in = '{spi_en: spi_en, spi_mode: spi_mode, fifo_mode: fifo_mode};

  ssf_ctrl_watch #(.FIFO_SUPPORTED(FIFO_SUPPORTED)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_in  (ctrl_in),
    .ctrl_eff (ctrl_eff),
    .ctrl_q   (ctrl_q),
    .soft_rst (soft_rst)
  );

  assign fifo_q = ctrl_q.fifo_mode;
  assign tx_cap = fifo_q ? OCC_FULL : OCC_ONE;

  assign tx_push_g = tx_push && !soft_rst;
  assign tx_pop_g  = tx_pop && !soft_rst;
  assign rx_push_g = xfer_done && fifo_q && !soft_rst;
  assign rx_pop_g  = data_rd && fifo_q && !soft_rst;

  ssf_occ_counter #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_tx_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .cap     (tx_cap),
    .push    (tx_push_g),
    .pop     (tx_pop_g),
    .occ     (tx_occ),
    .occ_nxt (tx_nxt)
  );

  ssf_occ_counter #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_rx_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .cap     (OCC_FULL),
    .push    (rx_push_g),
    .pop     (rx_pop_g),
    .occ     (rx_occ),
    .occ_nxt (rx_nxt)
  );

  assign rx_nf_cross = fifo_q && !soft_rst && rises_to(int'(rx_occ), int'(rx_nxt), RX_NF_LVL);
  assign tx_ne_cross = fifo_q && !soft_rst && falls_to(int'(tx_occ), int'(tx_nxt), TX_NE_LVL);

  // Set sources and soft-reset values of the sticky flags
  always_comb begin
    fl_set           = '0;
    fl_set[FL_MATCH] = match_evt && !soft_rst;
    fl_set[FL_MODF]  = modf_evt && !soft_rst;
    fl_set[FL_RXNF]  = rx_nf_cross;
    fl_set[FL_TXNE]  = tx_ne_cross;
    fl_soft          = '0;
    fl_soft[FL_TXNE] = ctrl_eff.fifo_mode;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_STICKY; gi++) begin : g_sticky
      assign fl_clr[gi] = wr_stb && wr_data[FLAG_POS[gi]];
      ssf_sticky_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .soft_val (fl_soft[gi]),
        .set      (fl_set[gi]),
        .clr      (fl_clr[gi]),
        .q        (fl_q[gi])
      );
    end
  endgenerate

  ssf_rdfull u_rdfull (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .active   (!fifo_q),
    .set      (xfer_done),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .dma_en   (rx_dma_en),
    .flag     (rdfull_nf)
  );

  always_comb begin
    status            = '0;
    status[ST_RDFULL] = fifo_q ? (rx_occ == OCC_FULL) : rdfull_nf;
    status[ST_MATCH]  = fl_q[FL_MATCH];
    status[ST_TXEMP]  = (tx_occ == '0);
    status[ST_MODF]   = fl_q[FL_MODF];
    if (fifo_q) begin
      status[ST_RXNF]   = fl_q[FL_RXNF];
      status[ST_TXNE]   = fl_q[FL_TXNE];
      status[ST_TXFULL] = (tx_occ == OCC_FULL);
      status[ST_RXEMP]  = (rx_occ == '0);
    end
  end

  assign rx_nf_irq = rx_nf_ie && status[ST_RXNF];
  assign tx_ne_irq = tx_ne_ie && status[ST_TXNE];

endmodule

// File: rtl/ssf_status_chk.sv
module ssf_status_chk #(
  parameter int DEPTH = 8,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             tx_push,
  input logic             tx_pop,
  input logic             xfer_done,
  input logic             data_rd,
  input logic             wr_stb,
  input logic [7:0]       wr_data,
  input logic             match_evt,
  input logic             modf_evt,
  input logic             rx_nf_ie,
  input logic             tx_ne_ie,
  input logic [7:0]       status,
  input logic             rx_nf_irq,
  input logic             tx_ne_irq,
  input logic             soft_rst,
  input logic [OCC_W-1:0] tx_occ,
  input logic [OCC_W-1:0] rx_occ
);

  p_soft_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[7:6] == 2'b00) && status[5] && !status[4] && !status[3] && !status[1]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_occ) <= DEPTH) && (int'(rx_occ) <= DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !soft_rst && status[1] && tx_push && !tx_pop) |=> status[1]);

  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !soft_rst && status[0] && data_rd && !xfer_done) |=> status[0]);

  p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data[6] && !match_evt && !soft_rst) |=> !status[6]);

  p_w1c_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(wr_stb && wr_data[4]) && !soft_rst) |=> status[4]);

  p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !soft_rst) |-> (status[3:0] == 4'h0));

  p_rdfull_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !soft_rst && xfer_done) |=> status[7]);

  p_rdfull_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !soft_rst && status[7] && !data_rd) |=> status[7]);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_nf_ie |-> !rx_nf_irq) and (!tx_ne_ie |-> !tx_ne_irq));

  p_event_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && modf_evt) |=> status[4]);

endmodule

bind spi_fifo_status ssf_status_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_mode (fifo_mode),
  .tx_push   (tx_push),
  .tx_pop    (tx_pop),
  .xfer_done (xfer_done),
  .data_rd   (data_rd),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .match_evt (match_evt),
  .modf_evt  (modf_evt),
  .rx_nf_ie  (rx_nf_ie),
  .tx_ne_ie  (tx_ne_ie),
  .status    (status),
  .rx_nf_irq (rx_nf_irq),
  .tx_ne_irq (tx_ne_irq),
  .soft_rst  (soft_rst),
  .tx_occ    (tx_occ),
  .rx_occ    (rx_occ)
);

// File: tb/spi_fifo_status_tb.sv
`timescale 1ns/1ps
module spi_fifo_status_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 0, spi_mode = 0, fifo_mode = 0, rx_dma_en = 0;
  logic rx_nf_ie = 0, tx_ne_ie = 0;
  logic tx_push = 0, tx_pop = 0, xfer_done = 0, data_rd = 0, stat_rd = 0;
  logic wr_stb = 0;
  logic [7:0] wr_data = 8'h00;
  logic match_evt = 0, modf_evt = 0;
  logic [7:0] status;
  logic rx_nf_irq, tx_ne_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_fifo_status u_dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .spi_mode(spi_mode),
    .fifo_mode(fifo_mode), .rx_dma_en(rx_dma_en), .rx_nf_ie(rx_nf_ie),
    .tx_ne_ie(tx_ne_ie), .tx_push(tx_push), .tx_pop(tx_pop),
    .xfer_done(xfer_done), .data_rd(data_rd), .stat_rd(stat_rd),
    .wr_stb(wr_stb), .wr_data(wr_data), .match_evt(match_evt),
    .modf_evt(modf_evt), .status(status), .rx_nf_irq(rx_nf_irq),
    .tx_ne_irq(tx_ne_irq)
  );

  // One clock edge, then sample 1 ns later and drop the strobes
  task automatic cyc();
    @(posedge clk);
    #1;
    tx_push = 0; tx_pop = 0; xfer_done = 0; data_rd = 0; stat_rd = 0;
    wr_stb = 0; wr_data = 8'h00; match_evt = 0; modf_evt = 0;
  endtask

  task automatic chk(string req, string what, logic [7:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s %s: status=%02h expected=%02h", req, what, status, exp);
    end
  endtask

  task automatic chk_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: value=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic n_tx_push(int n);
    for (int i = 0; i < n; i++) begin tx_push = 1; cyc(); end
  endtask
  task automatic n_tx_pop(int n);
    for (int i = 0; i < n; i++) begin tx_pop = 1; cyc(); end
  endtask
  task automatic n_xfer(int n);
    for (int i = 0; i < n; i++) begin xfer_done = 1; cyc(); end
  endtask
  task automatic n_drd(int n);
    for (int i = 0; i < n; i++) begin data_rd = 1; cyc(); end
  endtask
  task automatic wr(logic [7:0] d);
    wr_stb = 1; wr_data = d; cyc();
  endtask

  task automatic t_reset();
    chk("R1", "after reset", 8'h20);
    chk_bit("R1", "rx irq after reset", rx_nf_irq, 1'b0);
    chk_bit("R1", "tx irq after reset", tx_ne_irq, 1'b0);
    cyc(); cyc(); cyc();
    chk("R1", "idle hold", 8'h20);
  endtask

  task automatic t_enter_fifo();
    fifo_mode = 1; spi_en = 1; tx_push = 1;
    cyc();
    chk("R2", "soft reset into FIFO mode, push ignored", 8'h25);
    cyc();
    chk("R2", "stable after soft reset", 8'h25);
  endtask

  task automatic t_fifo_tx();
    wr(8'h04);
    chk("R6", "clear tx near-empty", 8'h21);
    n_tx_push(1);
    chk("R3", "one tx entry", 8'h01);
    n_tx_push(7);
    chk("R3", "tx full at 8", 8'h03);
    n_tx_push(1);
    chk("R3", "push to full", 8'h03);
    n_tx_pop(7);
    chk("R5", "tx near-empty crossing", 8'h05);
    chk_bit("R11", "tx irq disabled", tx_ne_irq, 1'b0);
    tx_ne_ie = 1; #1;
    chk_bit("R11", "tx irq enabled", tx_ne_irq, 1'b1);
    n_tx_pop(1);
    chk("R3", "ninth push was dropped", 8'h25);
    n_tx_pop(1);
    n_tx_push(1);
    chk("R3", "pop from empty ignored", 8'h05);
    n_tx_pop(1);
    tx_ne_ie = 0;
  endtask

  task automatic t_fifo_rx();
    wr(8'h04);
    chk("R6", "clear tx near-empty again", 8'h21);
    n_xfer(5);
    chk("R4", "rx occupancy 5", 8'h20);
    n_xfer(1);
    chk("R5", "rx near-full crossing", 8'h28);
    chk_bit("R11", "rx irq disabled", rx_nf_irq, 1'b0);
    rx_nf_ie = 1; cyc();
    chk_bit("R11", "rx irq enabled", rx_nf_irq, 1'b1);
    n_xfer(2);
    chk("R4", "rx full", 8'hA8);
    n_xfer(1);
    n_drd(1);
    chk("R4", "extra rx push dropped", 8'h28);
    wr(8'h08);
    chk("R6", "clear rx near-full", 8'h20);
    chk_bit("R11", "rx irq after clear", rx_nf_irq, 1'b0);
    n_xfer(1);
    chk("R5", "no re-set above watermark", 8'hA0);
    n_drd(8);
    chk("R4", "rx empty", 8'h21);
    n_drd(1);
    n_xfer(1);
    chk("R4", "pop from empty ignored", 8'h20);
    n_drd(1);
    rx_nf_ie = 0;
  endtask

  task automatic t_events();
    match_evt = 1; cyc();
    chk("R12", "match sets bit 6", 8'h61);
    modf_evt = 1; cyc();
    chk("R12", "mode fault sets bit 4", 8'h71);
    wr(8'h00);
    chk("R6", "zero write no effect", 8'h71);
    wr(8'hAF);
    chk("R6", "write to other bits no effect", 8'h71);
    wr_stb = 1; wr_data = 8'h40; match_evt = 1; cyc();
    chk("R6", "set wins over clear", 8'h71);
    wr(8'h50);
    chk("R6", "clear bits 6 and 4", 8'h21);
  endtask

  task automatic t_soft_busy();
    n_tx_push(3);
    n_xfer(7);
    match_evt = 1; cyc();
    chk("R5", "busy state before soft reset", 8'h48);
    spi_mode = 1; cyc();
    chk("R2", "spi mode change empties FIFOs", 8'h25);
  endtask

  task automatic t_buffered();
    fifo_mode = 0; cyc();
    chk("R2", "soft reset into buffered mode", 8'h20);
    n_tx_push(1);
    chk("R7", "tx buffer loaded", 8'h00);
    n_tx_push(1);
    n_tx_pop(1);
    chk("R7", "second push dropped", 8'h20);
    n_xfer(1);
    chk("R8", "read-full set, low bits zero", 8'hA0);
    n_drd(1);
    chk("R9", "data read without status read", 8'hA0);
    stat_rd = 1; cyc();
    n_drd(1);
    chk("R9", "status then data read clears", 8'h20);
    n_xfer(1);
    stat_rd = 1; cyc();
    n_xfer(1);
    n_drd(1);
    chk("R9", "new transfer needs new status read", 8'hA0);
    stat_rd = 1; cyc();
    n_drd(1);
    chk("R9", "cleared after fresh status read", 8'h20);
    rx_dma_en = 1;
    n_xfer(1);
    n_drd(1);
    chk("R10", "DMA data read clears", 8'h20);
    rx_dma_en = 0;
    n_xfer(1);
    spi_en = 0; cyc();
    chk("R2", "disable clears read-full", 8'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all watchdog: state=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12;
    rst_n = 1;
    #1;
    cyc();
    t_reset();
    t_enter_fifo();
    t_fifo_tx();
    t_fifo_rx();
    t_events();
    t_soft_busy();
    t_buffered();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule